// File: doc/BRIEF.md
# Quadrature Output Startup Sequencer

This block drives the A/B/Z incremental encoder outputs from an absolute position within one signal period. After reset release it keeps all three outputs low for a settling interval of 20 ms. The interval is counted in clock cycles and derived from a clock-frequency parameter. At the end of that interval it takes one of three startup behaviours, chosen by a 2-bit mode input. After that it moves into incremental tracking, where each position step becomes one Gray-coded quadrature step.

The three startup behaviours work as follows.
- **Hold low:** A/B start in the all-low state, with no fixed relation to Z.
- **Absolute preset:** A/B are loaded with the quadrature state of the absolute position plus a programmable phase offset. The A/B-to-Z phase is therefore the same on every startup.
- **Burst:** the absolute position is replayed as a train of quadrature edges, which a counting receiver can total.

A halt input silences the outputs. It does not touch any register access path, which lies outside this block. Releasing halt restarts the settling interval, so a reconfiguration produces no stray edges.

Top module: `qenc_startup_seq`

## Requirements
- R1: The quadrature state s (0..3) drives the outputs as {qa,qb}: s0 = 00, s1 = 10, s2 = 11, s3 = 01. Rising s is forward motion.
- R2: During reset, and for SETTLE_CYC = (CLK_HZ/1000)*SETTLE_MS clock edges after reset release, qa, qb and qz are all 0. The startup action takes effect on edge SETTLE_CYC.
- R3: For mode 00 and for the reserved mode 01, A/B enter tracking in state s0 whatever abs_pos and phase_ofs are.
- R4: For mode 10, A/B enter tracking in state (abs_pos + phase_ofs) mod 4.
- R5: For mode 11 with abs_pos nonzero, the block emits exactly abs_pos quadrature edges starting from s0. The first edge comes EDGE_GAP cycles after the settling interval, and each later edge follows EDGE_GAP cycles after the one before. Z stays 0 throughout, and the burst ends in state abs_pos mod 4 before tracking starts. With abs_pos = 0 there is no burst and phase_ofs is ignored.
- R6: In tracking, the internal follower moves one step per cycle toward abs_pos along the shorter way round the period. Each step changes exactly one of qa, qb.
- R7: In tracking, qz is 1 exactly while the follower position equals 0, which is one quadrature state.
- R8: When halt is 1 at a clock edge, qa, qb and qz are 0 after that edge. When halt returns to 0, the outputs stay 0 for another SETTLE_CYC edges and the startup sequence then runs again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Startup behaviour: 00 hold low, 01 reserved (as 00), 10 absolute preset, 11 burst |
| halt | input | 1 | Stops all output generation while 1 |
| phase_ofs | input | 2 | Quadrature-state offset applied in absolute preset mode |
| abs_pos | input | POS_W | Absolute position within one period, in quadrature states |
| qa | output | 1 | Quadrature channel A |
| qb | output | 1 | Quadrature channel B |
| qz | output | 1 | Index pulse |

## Verification
The bench measures the settling boundary to the exact edge. A timer that is off by one would show its first A/B level one cycle early or late. In burst mode it counts every A/B edge and its cycle of arrival, which exposes a wrong edge count, a wrong spacing, or a burst that starts tracking in the wrong state. It moves the follower backwards across zero and then forwards across zero to check the shorter-path direction and a one-cycle Z, so a tracker that takes the long way round or misplaces Z is caught. It also releases halt mid-run to confirm that the full settling wait is served again rather than skipped.

// File: rtl/qss_pkg.sv
// Shared definitions for the quadrature startup sequencer.
// Assumes quadrature states are numbered 0..3 in the forward direction.
package qss_pkg;

    typedef enum logic [1:0] {
        ST_SETTLE = 2'd0,
        ST_BURST  = 2'd1,
        ST_TRACK  = 2'd2
    } qss_state_e;

    localparam logic [1:0] MODE_HOLD  = 2'b00;
    localparam logic [1:0] MODE_RSVD  = 2'b01;
    localparam logic [1:0] MODE_ABS   = 2'b10;
    localparam logic [1:0] MODE_BURST = 2'b11;

    // Map a quadrature state to {A,B} so that adjacent states differ in one bit.
    function automatic logic [1:0] quad_ab(input logic [1:0] s);
        case (s)
            2'd0:    quad_ab = 2'b00;
            2'd1:    quad_ab = 2'b10;
            2'd2:    quad_ab = 2'b11;
            default: quad_ab = 2'b01;
        endcase
    endfunction

endpackage

// File: rtl/qss_settle_timer.sv
// Settling timer: counts up from 0 while enabled and raises done once
// CYC-1 has been reached. Assumes CYC >= 2. clr restarts the count.
module qss_settle_timer #(
    parameter int CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic done
);
    localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

    logic [CW-1:0] cnt;

    assign done = (cnt == CW'(CYC - 1));

    // Count settling cycles and saturate at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/qss_burst_gen.sv
// Burst generator: after start, advances a quadrature phase once every
// GAP cycles until count steps have been made. Assumes start is given
// only with a nonzero count. last marks the cycle whose edge makes the final step.
module qss_burst_gen #(
    parameter int POS_W = 8,
    parameter int GAP   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             start,
    input  logic [POS_W-1:0] count,
    output logic             active,
    output logic [1:0]       phase,
    output logic             last,
    output logic [POS_W-1:0] origin
);
    localparam int GW = (GAP > 1) ? $clog2(GAP) : 1;

    logic [POS_W-1:0] rem;
    logic [GW-1:0]    gap_cnt;
    logic             gap_end;

    assign gap_end = (gap_cnt == GW'(GAP - 1));
    assign last    = active && gap_end && (rem == POS_W'(1));

    // Pace the burst: one phase step per GAP cycles until rem is used up.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            active  <= 1'b0;
            rem     <= '0;
            gap_cnt <= '0;
            phase   <= 2'd0;
            origin  <= '0;
        end else if (start) begin
            origin  <= count;
            rem     <= count;
            gap_cnt <= '0;
            phase   <= 2'd0;
            active  <= (count != '0);
        end else if (active) begin
            if (gap_end) begin
                gap_cnt <= '0;
                phase   <= phase + 2'd1;
                rem     <= rem - 1'b1;
                if (rem == POS_W'(1)) active <= 1'b0;
            end else begin
                gap_cnt <= gap_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/qss_tracker.sv
// Position follower: moves one step per cycle toward target along the
// shorter way round the period and presents the quadrature A/B state
// offset by a loaded 2-bit base. Assumes target changes are tracked
// at no more than one step per cycle.
module qss_tracker #(
    parameter int POS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [POS_W-1:0] load_pos,
    input  logic [1:0]       load_base,
    input  logic             run,
    input  logic [POS_W-1:0] target,
    output logic [1:0]       ab,
    output logic             at_zero
);
    import qss_pkg::*;

    logic [POS_W-1:0] fpos;
    logic [1:0]       base;
    logic [POS_W-1:0] diff;

    assign diff    = target - fpos;
    assign ab      = quad_ab(fpos[1:0] + base);
    assign at_zero = (fpos == '0);

    // Load the start point, then step toward the target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fpos <= '0;
            base <= 2'd0;
        end else if (load) begin
            fpos <= load_pos;
            base <= load_base;
        end else if (run && (diff != '0)) begin
            fpos <= diff[POS_W-1] ? fpos - 1'b1 : fpos + 1'b1;
        end
    end
endmodule

// File: rtl/qenc_startup_seq.sv
// Top: sequences A/B/Z from reset release through settling, the selected
// startup action and incremental tracking. Assumes abs_pos is synchronous
// to clk and counts quadrature states within one period.
module qenc_startup_seq #(
    parameter int CLK_HZ    = 50_000_000,
    parameter int SETTLE_MS = 20,
    parameter int POS_W     = 8,
    parameter int EDGE_GAP  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             halt,
    input  logic [1:0]       phase_ofs,
    input  logic [POS_W-1:0] abs_pos,
    output logic             qa,
    output logic             qb,
    output logic             qz
);
    import qss_pkg::*;

    localparam int SETTLE_CYC = (CLK_HZ / 1000) * SETTLE_MS;

    qss_state_e       state;
    logic             tmr_clr, tmr_done, go;
    logic             bst_start, bst_active, bst_last;
    logic [1:0]       bst_phase;
    logic [POS_W-1:0] bst_origin;
    logic             trk_load, trk_run, trk_zero;
    logic [POS_W-1:0] trk_pos;
    logic [1:0]       trk_base, trk_ab, burst_ab;

    // Derive the control strobes for the sub-blocks from the state.
    always_comb begin
        tmr_clr   = (state != ST_SETTLE) || halt;
        go        = (state == ST_SETTLE) && tmr_done && !halt;
        bst_start = go && (mode == MODE_BURST) && (abs_pos != '0);
        trk_load  = (go && !bst_start) || ((state == ST_BURST) && bst_last && !halt);
        trk_run   = (state == ST_TRACK) && !halt;
        trk_pos   = (state == ST_BURST) ? bst_origin : abs_pos;
        case (mode)
            MODE_HOLD, MODE_RSVD: trk_base = 2'd0 - abs_pos[1:0];
            MODE_ABS:             trk_base = phase_ofs;
            default:              trk_base = 2'd0;
        endcase
        if (state == ST_BURST) trk_base = 2'd0;
    end

    // Advance the sequence; reset or halt send it back to settling.
    always_ff @(posedge clk) begin
        if (!rst_n || halt) begin
            state <= ST_SETTLE;
        end else begin
            case (state)
                ST_SETTLE: if (go) state <= bst_start ? ST_BURST : ST_TRACK;
                ST_BURST:  if (bst_last) state <= ST_TRACK;
                ST_TRACK:  state <= ST_TRACK;
                default:   state <= ST_SETTLE;
            endcase
        end
    end

    qss_settle_timer #(.CYC(SETTLE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .done  (tmr_done)
    );

    qss_burst_gen #(.POS_W(POS_W), .GAP(EDGE_GAP)) u_burst (
        .clk    (clk),
        .rst_n  (rst_n),
        .abort  (halt),
        .start  (bst_start),
        .count  (abs_pos),
        .active (bst_active),
        .phase  (bst_phase),
        .last   (bst_last),
        .origin (bst_origin)
    );

    qss_tracker #(.POS_W(POS_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (trk_load),
        .load_pos  (trk_pos),
        .load_base (trk_base),
        .run       (trk_run),
        .target    (abs_pos),
        .ab        (trk_ab),
        .at_zero   (trk_zero)
    );

    assign burst_ab = quad_ab(bst_phase);

    // Select the output source: tracker, burst phase, or silent.
    always_comb begin
        qa = 1'b0;
        qb = 1'b0;
        qz = 1'b0;
        if (state == ST_TRACK) begin
            {qa, qb} = trk_ab;
            qz       = trk_zero;
        end else if ((state == ST_BURST) && bst_active) begin
            {qa, qb} = burst_ab;
        end
    end
endmodule

// File: rtl/qss_checks.sv
// Checker for qenc_startup_seq: observes ports only and keeps its own
// count of cycles since reset release or halt release.
module qss_checks #(
    parameter int SETTLE_CYC = 100
) (
    input logic clk,
    input logic rst_n,
    input logic halt,
    input logic qa,
    input logic qb,
    input logic qz
);
    localparam int QW = $clog2(SETTLE_CYC + 1);

    logic [QW-1:0] quiet_cnt;
    logic          armed;

    // Count edges since the last reset or halt, saturating at SETTLE_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n || halt) begin
            quiet_cnt <= '0;
        end else if (quiet_cnt != QW'(SETTLE_CYC)) begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    // Mark that at least one cycle has passed out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2
    settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_cnt < QW'(SETTLE_CYC)) |-> (!qa && !qb && !qz));

    // R8
    halt_silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (!qa && !qb && !qz));

    // R6
    single_bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(halt) && ($past({qa, qb}) != 2'b00))
        |-> ($countones({qa, qb} ^ $past({qa, qb})) <= 1));

    // R7
    index_one_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && qz && $past(qz)) |-> ({qa, qb} == $past({qa, qb})));
endmodule

bind qenc_startup_seq qss_checks #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .halt  (halt),
    .qa    (qa),
    .qb    (qb),
    .qz    (qz)
);

// File: tb/sim_qenc_startup_seq.sv
module sim_qenc_startup_seq;
    localparam int CLK_HZ = 5000;
    localparam int SMS    = 20;
    localparam int SET    = (CLK_HZ / 1000) * SMS;
    localparam int GAP    = 4;
    localparam int NV     = 10;

    // {mode[1:0], ofs[1:0], pos[7:0], a, b, z}
    localparam logic [14:0] VEC [0:NV-1] = '{
        {2'b00, 2'd0, 8'd6, 3'b000},   // R3 hold low
        {2'b01, 2'd3, 8'd9, 3'b000},   // R3 reserved acts as hold
        {2'b10, 2'd0, 8'd5, 3'b100},   // R4 state 1
        {2'b10, 2'd2, 8'd5, 3'b010},   // R4 state 3
        {2'b10, 2'd3, 8'd0, 3'b011},   // R4 R7 offset with Z
        {2'b11, 2'd0, 8'd6, 3'b110},   // R5 ends in state 2
        {2'b11, 2'd2, 8'd0, 3'b001},   // R5 zero position, no burst
        {2'b00, 2'd1, 8'd0, 3'b001},   // R3 R7 Z at zero
        {2'b10, 2'd1, 8'd2, 3'b010},   // R4 state 3
        {2'b11, 2'd0, 8'd3, 3'b010}    // R5 ends in state 3
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       halt = 1'b0;
    logic [1:0] phase_ofs = 2'd0;
    logic [7:0] abs_pos = 8'd0;
    logic       qa, qb, qz;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    qenc_startup_seq #(
        .CLK_HZ(CLK_HZ), .SETTLE_MS(SMS), .POS_W(8), .EDGE_GAP(GAP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .halt(halt),
        .phase_ofs(phase_ofs), .abs_pos(abs_pos),
        .qa(qa), .qb(qb), .qz(qz)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start(input logic [1:0] m, input logic [1:0] o, input logic [7:0] p);
        @(negedge clk);
        rst_n = 1'b0;
        mode = m; phase_ofs = o; abs_pos = p; halt = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        int t;
        int cnt;
        int last_i;
        logic [1:0] prev;

        // Reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R2 reset outputs", {qa, qb, qz}, 0);

        // Vector table: handover state per mode
        for (int i = 0; i < NV; i++) begin
            start(VEC[i][14:13], VEC[i][12:11], VEC[i][10:3]);
            edges(SET + 8 + 4 * GAP * 10 + int'(VEC[i][10:3]) * GAP);
            chk($sformatf("R3/R4/R5 vector %0d abz", i), {qa, qb, qz}, int'(VEC[i][2:0]));
        end

        // R2 exact settling boundary in absolute mode
        start(2'b10, 2'd0, 8'd1);
        edges(SET - 1);
        chk("R2 low before boundary", {qa, qb, qz}, 0);
        edges(1);
        chk("R2 R4 preset at boundary", {qa, qb, qz}, 3'b100);

        // R5 burst count and spacing
        start(2'b11, 2'd0, 8'd5);
        edges(SET);
        chk("R5 burst starts at s0", {qa, qb}, 0);
        prev = {qa, qb};
        cnt = 0; last_i = 0;
        for (int i = 1; i <= 5 * GAP + 10; i++) begin
            edges(1);
            if (qz) chk("R5 Z low during burst", 1, 0);
            if ({qa, qb} != prev) begin
                cnt++;
                chk("R5 edge spacing", i - last_i, GAP);
                chk("R1 R6 one bit per edge", $countones({qa, qb} ^ prev), 1);
                last_i = i;
                prev = {qa, qb};
            end
        end
        chk("R5 burst edge count", cnt, 5);
        chk("R5 burst end state", {qa, qb}, 2'b10);

        // R6 R7 tracking across zero both ways
        start(2'b00, 2'd0, 8'd0);
        edges(SET + 1);
        chk("R7 Z at zero", {qa, qb, qz}, 3'b001);
        @(negedge clk) abs_pos = 8'd1;
        edges(1);
        chk("R1 R6 forward step", {qa, qb, qz}, 3'b100);
        @(negedge clk) abs_pos = 8'd255;
        edges(1);
        chk("R7 back through zero", {qa, qb, qz}, 3'b001);
        edges(1);
        chk("R6 reverse step to s3", {qa, qb, qz}, 3'b010);
        @(negedge clk) abs_pos = 8'd3;
        edges(1);
        chk("R6 short way forward Z", {qa, qb, qz}, 3'b001);
        edges(1);
        chk("R7 Z one state", qz, 0);
        edges(2);
        chk("R6 arrive at 3", {qa, qb, qz}, 3'b010);

        // R8 halt and restart
        @(negedge clk) halt = 1'b1;
        edges(1);
        chk("R8 halt silences", {qa, qb, qz}, 0);
        edges(5);
        chk("R8 stays silent", {qa, qb, qz}, 0);
        @(negedge clk) halt = 1'b0;
        edges(SET - 1);
        chk("R8 settling served again", {qa, qb, qz}, 0);
        edges(1);
        chk("R8 R3 restart hold state", {qa, qb, qz}, 3'b000);

        t = 0;
        done = 1'b1;
    end

    initial begin
        int n = 0;
        while (!done && n < 150000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=done", n);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule